// File: doc/BRIEF.md
# Sliding-Window Pixel Cluster Finder

This block groups the pixel hits of one sensor module into clusters of touching pixels. Hits arrive as column, row and charge words, already sorted by row and then by column. They are collected into a pending buffer until an end-of-module strobe arrives. The block then repeatedly takes the earliest pending hit as a seed and places a fixed window of 21 rows by 8 columns around it. The seed occupies the window's first row and sits at column offset 4. All pending hits inside the window are loaded into a two-dimensional cell array. The selection then grows outward by one ring of neighbours per clock until a step adds nothing.

The selected hits leave as one cluster, one hit per clock, with the final hit flagged. Hits that were not selected stay pending and seed later clusters. When nothing is pending, the block accepts the next module. Centroid computation is left to a downstream stage.

Top module: `pix_cluster_finder`

## Requirements
- R1: After reset the block is ready for input (`in_ready_o` high) and emits no cluster beat.
- R2: A hit is stored when `hit_valid_i` and `in_ready_o` are both high. `eom_i` seen while ready starts processing, and `in_ready_o` stays low until every pending hit has been emitted. A module that has no hits returns to ready without emitting anything.
- R3: Each cluster begins with its seed, which is the earliest remaining hit in arrival order.
- R4: A cluster holds only hits whose row lies 0 to 20 above the seed row and whose column lies 4 below to 3 above the seed column. A chain that extends past this window is split into further clusters.
- R5: Two hits are connected when their columns and their rows each differ by at most one (8-connectivity). A cluster is exactly the connected set of in-window hits that contains the seed.
- R6: Pending hits that a cluster does not take are kept, and they form later clusters in seed order. There is at least one idle cycle between clusters.
- R7: Cluster beats are contiguous. They are ordered by row and then by column, and `clu_last_o` is high on the final beat only. Column, row and charge leave unchanged.
- R8: Processing a cluster takes one seed cycle, one load cycle per stored hit, one growth cycle per added ring plus one closing cycle, and then one cycle per beat. For a module with a single hit, the beat is visible in the third cycle after the cycle in which `eom_i` is sampled.
- R9: The buffer holds DEPTH hits. When it is full, `in_ready_o` drops, further hits are lost, and `eom_i` is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | 1 | Hit word present |
| hit_col_i | input | COL_W | Hit column |
| hit_row_i | input | ROW_W | Hit row |
| hit_chg_i | input | CHG_W | Hit charge |
| eom_i | input | 1 | End of module, starts clustering |
| in_ready_o | output | 1 | Accepting hits and end-of-module |
| clu_valid_o | output | 1 | Cluster beat present |
| clu_last_o | output | 1 | Final beat of a cluster |
| clu_col_o | output | COL_W | Member column |
| clu_row_o | output | ROW_W | Member row |
| clu_chg_o | output | CHG_W | Member charge |

## Verification
The only latency fixed by the inputs alone is the one for a lone hit. Its beat must appear exactly three cycles after the edge that samples the end-of-module strobe, so the bench counts falling edges from that point and checks for that count. For every other module, the bench runs a behavioural flood-fill model restricted to the window and queues the expected beats before the strobe. On each falling edge, any beat on the outputs is compared with the head of that queue. Readiness returning high marks the point at which the bench checks that the queue has drained and counts the clusters against hand-derived totals.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_SEED,
    ST_LOAD,
    ST_GROW,
    ST_EMIT
  } pcf_state_e;
endpackage

// File: rtl/pcf_hit_store.sv
module pcf_hit_store #(
  parameter int COL_W = 8,
  parameter int ROW_W = 9,
  parameter int CHG_W = 8,
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [CHG_W-1:0] wr_chg_i,
  input  logic             clear_i,
  input  logic             kill_en_i,
  input  logic [IDX_W-1:0] kill_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [COL_W-1:0] rd_col_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [CHG_W-1:0] rd_chg_o,
  output logic             rd_live_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             any_live_o,
  output logic [IDX_W-1:0] first_idx_o
);
  logic [COL_W-1:0] col_q [DEPTH];
  logic [ROW_W-1:0] row_q [DEPTH];
  logic [CHG_W-1:0] chg_q [DEPTH];
  logic [DEPTH-1:0] live_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_ok;

  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign wr_ok  = wr_en_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      live_q <= '0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      live_q <= '0;
    end else begin
      if (wr_ok) begin
        live_q[cnt_q[IDX_W-1:0]] <= 1'b1;
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (kill_en_i) live_q[kill_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) begin
      col_q[cnt_q[IDX_W-1:0]] <= wr_col_i;
      row_q[cnt_q[IDX_W-1:0]] <= wr_row_i;
      chg_q[cnt_q[IDX_W-1:0]] <= wr_chg_i;
    end
  end

  // earliest live entry = next seed
  always_comb begin
    first_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (live_q[i]) first_idx_o = IDX_W'(i);
    end
  end

  assign any_live_o = |live_q;
  assign cnt_o      = cnt_q;
  assign rd_col_o   = col_q[rd_idx_i];
  assign rd_row_o   = row_q[rd_idx_i];
  assign rd_chg_o   = chg_q[rd_idx_i];
  assign rd_live_o  = live_q[rd_idx_i];
endmodule

// File: rtl/pcf_cell_grid.sv
module pcf_cell_grid #(
  parameter int WIN_R = 21,
  parameter int WIN_C = 8,
  parameter int IDX_W = 5,
  localparam int RW = $clog2(WIN_R),
  localparam int CW = $clog2(WIN_C),
  localparam int N  = WIN_R * WIN_C,
  localparam int NW = $clog2(N),
  localparam int SEED_K = WIN_C / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_en_i,
  input  logic [RW-1:0]    load_r_i,
  input  logic [CW-1:0]    load_c_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic             grow_en_i,
  input  logic             pop_en_i,
  output logic             changed_o,
  output logic [IDX_W-1:0] pick_idx_o,
  output logic             pick_last_o
);
  logic [N-1:0]     occ_q, sel_q, sel_nx;
  logic [IDX_W-1:0] idx_q [N];
  logic [NW-1:0]    load_k, pick_k;
  logic             load_ok;

  assign load_k  = NW'(int'(load_r_i) * WIN_C + int'(load_c_i));
  assign load_ok = load_en_i && !occ_q[load_k];

  // one ring of 8-neighbours per step
  for (genvar r = 0; r < WIN_R; r++) begin : g_r
    for (genvar c = 0; c < WIN_C; c++) begin : g_c
      localparam int R0 = (r > 0) ? r - 1 : 0;
      localparam int R1 = (r < WIN_R - 1) ? r + 1 : WIN_R - 1;
      localparam int C0 = (c > 0) ? c - 1 : 0;
      localparam int C1 = (c < WIN_C - 1) ? c + 1 : WIN_C - 1;
      logic nb;
      always_comb begin
        nb = 1'b0;
        for (int rr = R0; rr <= R1; rr++)
          for (int cc = C0; cc <= C1; cc++)
            nb = nb | sel_q[rr*WIN_C+cc];
      end
      assign sel_nx[r*WIN_C+c] = occ_q[r*WIN_C+c] & nb;
    end
  end

  assign changed_o = (sel_nx != sel_q);

  always_comb begin
    pick_k = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel_q[i]) pick_k = NW'(i);
    end
  end

  assign pick_idx_o  = idx_q[pick_k];
  assign pick_last_o = ((sel_q & (sel_q - {{(N-1){1'b0}}, 1'b1})) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      sel_q <= '0;
    end else if (clear_i) begin
      occ_q <= '0;
      sel_q <= {{(N-1){1'b0}}, 1'b1} << SEED_K;
    end else begin
      if (load_ok) occ_q[load_k] <= 1'b1;
      if (grow_en_i) sel_q <= sel_nx;
      else if (pop_en_i) sel_q[pick_k] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_ok) idx_q[load_k] <= load_idx_i;
  end
endmodule

// File: rtl/pix_cluster_finder.sv
module pix_cluster_finder
  import pcf_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int ROW_W = 9,
  parameter int CHG_W = 8,
  parameter int DEPTH = 32,
  parameter int WIN_R = 21,
  parameter int WIN_C = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int RW = $clog2(WIN_R),
  localparam int CW = $clog2(WIN_C),
  localparam int HALF = WIN_C / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_valid_i,
  input  logic [COL_W-1:0] hit_col_i,
  input  logic [ROW_W-1:0] hit_row_i,
  input  logic [CHG_W-1:0] hit_chg_i,
  input  logic             eom_i,
  output logic             in_ready_o,
  output logic             clu_valid_o,
  output logic             clu_last_o,
  output logic [COL_W-1:0] clu_col_o,
  output logic [ROW_W-1:0] clu_row_o,
  output logic [CHG_W-1:0] clu_chg_o
);
  pcf_state_e       st_q;
  logic [COL_W-1:0] seed_col_q, rd_col;
  logic [ROW_W-1:0] seed_row_q, rd_row;
  logic [CHG_W-1:0] rd_chg;
  logic [IDX_W-1:0] ld_idx_q, rd_idx, first_idx, pick_idx;
  logic [CNT_W-1:0] cnt;
  logic             rd_live, full, any_live, changed, pick_last;
  logic             ld_last, in_win, st_clear;
  logic [ROW_W:0]   dr;
  logic [COL_W+1:0] dc;

  assign in_ready_o = (st_q == ST_COLLECT) && !full;
  assign st_clear   = (st_q == ST_SEED) && !any_live;

  always_comb begin
    case (st_q)
      ST_SEED: rd_idx = first_idx;
      ST_LOAD: rd_idx = ld_idx_q;
      ST_EMIT: rd_idx = pick_idx;
      default: rd_idx = '0;
    endcase
  end

  pcf_hit_store #(
    .COL_W(COL_W), .ROW_W(ROW_W), .CHG_W(CHG_W), .DEPTH(DEPTH)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (hit_valid_i && in_ready_o),
    .wr_col_i   (hit_col_i),
    .wr_row_i   (hit_row_i),
    .wr_chg_i   (hit_chg_i),
    .clear_i    (st_clear),
    .kill_en_i  (st_q == ST_EMIT),
    .kill_idx_i (pick_idx),
    .rd_idx_i   (rd_idx),
    .rd_col_o   (rd_col),
    .rd_row_o   (rd_row),
    .rd_chg_o   (rd_chg),
    .rd_live_o  (rd_live),
    .full_o     (full),
    .cnt_o      (cnt),
    .any_live_o (any_live),
    .first_idx_o(first_idx)
  );

  // window offsets relative to seed; sign bit set means outside
  assign dr     = {1'b0, rd_row} - {1'b0, seed_row_q};
  assign dc     = {2'b0, rd_col} + (COL_W+2)'(HALF) - {2'b0, seed_col_q};
  assign in_win = rd_live && !dr[ROW_W] && (dr < (ROW_W+1)'(WIN_R))
                  && !dc[COL_W+1] && (dc < (COL_W+2)'(WIN_C));
  assign ld_last = ((CNT_W'(ld_idx_q) + CNT_W'(1)) == cnt);

  pcf_cell_grid #(
    .WIN_R(WIN_R), .WIN_C(WIN_C), .IDX_W(IDX_W)
  ) u_grid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (st_q == ST_SEED),
    .load_en_i  ((st_q == ST_LOAD) && in_win),
    .load_r_i   (dr[RW-1:0]),
    .load_c_i   (dc[CW-1:0]),
    .load_idx_i (ld_idx_q),
    .grow_en_i  (st_q == ST_GROW),
    .pop_en_i   (st_q == ST_EMIT),
    .changed_o  (changed),
    .pick_idx_o (pick_idx),
    .pick_last_o(pick_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_COLLECT;
      seed_col_q <= '0;
      seed_row_q <= '0;
      ld_idx_q   <= '0;
    end else begin
      case (st_q)
        ST_COLLECT: if (eom_i) st_q <= ST_SEED;
        ST_SEED: begin
          if (any_live) begin
            seed_col_q <= rd_col;
            seed_row_q <= rd_row;
            ld_idx_q   <= '0;
            st_q       <= ST_LOAD;
          end else begin
            st_q <= ST_COLLECT;
          end
        end
        ST_LOAD: begin
          ld_idx_q <= ld_idx_q + IDX_W'(1);
          if (ld_last) st_q <= ST_GROW;
        end
        ST_GROW: if (!changed) st_q <= ST_EMIT;
        ST_EMIT: if (pick_last) st_q <= ST_SEED;
        default: st_q <= ST_COLLECT;
      endcase
    end
  end

  assign clu_valid_o = (st_q == ST_EMIT);
  assign clu_last_o  = (st_q == ST_EMIT) && pick_last;
  assign clu_col_o   = rd_col;
  assign clu_row_o   = rd_row;
  assign clu_chg_o   = rd_chg;
endmodule

// File: rtl/pcf_checker.sv
module pcf_checker #(
  parameter int COL_W = 8,
  parameter int ROW_W = 9,
  parameter int WIN_R = 21,
  parameter int WIN_C = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             clu_valid_o,
  input logic             clu_last_o,
  input logic [COL_W-1:0] clu_col_o,
  input logic [ROW_W-1:0] clu_row_o
);
  logic             in_burst_q;
  logic [COL_W-1:0] s_col_q;
  logic [ROW_W-1:0] s_row_q;
  int               d_row, d_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_burst_q <= 1'b0;
      s_col_q    <= '0;
      s_row_q    <= '0;
    end else if (clu_valid_o) begin
      in_burst_q <= !clu_last_o;
      if (!in_burst_q) begin
        s_col_q <= clu_col_o;
        s_row_q <= clu_row_o;
      end
    end
  end

  always_comb begin
    d_row = int'(clu_row_o) - int'(s_row_q);
    d_col = int'(clu_col_o) - int'(s_col_q);
  end

  p_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o |-> !in_ready_o);
  p_last_has_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_last_o |-> clu_valid_o);
  p_burst_contig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o && !clu_last_o |=> clu_valid_o);
  p_row_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o && !clu_last_o |=> clu_row_o >= $past(clu_row_o));
  p_gap_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o && clu_last_o |=> !clu_valid_o);
  p_win_row_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o && in_burst_q |-> (d_row >= 0) && (d_row < WIN_R));
  p_win_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_o && in_burst_q |-> (d_col >= -(WIN_C/2)) && (d_col < WIN_C - WIN_C/2));
endmodule

bind pix_cluster_finder pcf_checker #(
  .COL_W(COL_W), .ROW_W(ROW_W), .WIN_R(WIN_R), .WIN_C(WIN_C)
) u_pcf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .clu_valid_o(clu_valid_o),
  .clu_last_o (clu_last_o),
  .clu_col_o  (clu_col_o),
  .clu_row_o  (clu_row_o)
);

// File: tb/tb_pix_cluster_finder.sv
module tb_pix_cluster_finder;
  localparam int COL_W = 8, ROW_W = 9, CHG_W = 8, DEPTH = 32, WIN_R = 21, WIN_C = 8;
  localparam int HALF = WIN_C / 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hit_valid = 1'b0, eom = 1'b0;
  logic [COL_W-1:0] hit_col = '0;
  logic [ROW_W-1:0] hit_row = '0;
  logic [CHG_W-1:0] hit_chg = '0;
  logic in_ready, clu_valid, clu_last;
  logic [COL_W-1:0] clu_col;
  logic [ROW_W-1:0] clu_row;
  logic [CHG_W-1:0] clu_chg;

  always #5 clk = ~clk;

  pix_cluster_finder #(
    .COL_W(COL_W), .ROW_W(ROW_W), .CHG_W(CHG_W), .DEPTH(DEPTH), .WIN_R(WIN_R), .WIN_C(WIN_C)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .hit_valid_i(hit_valid), .hit_col_i(hit_col),
    .hit_row_i(hit_row), .hit_chg_i(hit_chg), .eom_i(eom), .in_ready_o(in_ready),
    .clu_valid_o(clu_valid), .clu_last_o(clu_last), .clu_col_o(clu_col),
    .clu_row_o(clu_row), .clu_chg_o(clu_chg)
  );

  int n_chk = 0, n_fail = 0, n_last = 0, cyc = 0;
  int hc[$], hr[$], hq[$];
  int ec[$], er[$], eq[$], el[$];
  bit mid = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // windowed flood-fill model over accepted hits, in arrival order
  function automatic int build_expected();
    int n = hc.size();
    bit live[64], inw[64], sel[64];
    int nclu = 0;
    for (int i = 0; i < n; i++) live[i] = 1;
    while (1) begin
      int s = -1, lst = -1;
      bit grew = 1;
      for (int i = n - 1; i >= 0; i--) if (live[i]) s = i;
      if (s < 0) break;
      for (int i = 0; i < n; i++) begin
        int drr = hr[i] - hr[s];
        int dcc = hc[i] - hc[s] + HALF;
        inw[i] = live[i] && drr >= 0 && drr < WIN_R && dcc >= 0 && dcc < WIN_C;
        sel[i] = (i == s);
      end
      while (grew) begin
        grew = 0;
        for (int i = 0; i < n; i++) begin
          if (inw[i] && !sel[i]) begin
            for (int j = 0; j < n; j++) begin
              if (sel[j] && !sel[i] && iabs(hc[i]-hc[j]) <= 1 && iabs(hr[i]-hr[j]) <= 1) begin
                sel[i] = 1;
                grew = 1;
              end
            end
          end
        end
      end
      for (int i = 0; i < n; i++) if (sel[i]) lst = i;
      for (int i = 0; i < n; i++) begin
        if (sel[i]) begin
          ec.push_back(hc[i]); er.push_back(hr[i]); eq.push_back(hq[i]);
          el.push_back(i == lst);
          live[i] = 0;
        end
      end
      nclu++;
    end
    return nclu;
  endfunction

  // beat monitor, compared on every falling edge
  always @(negedge clk) begin
    if (rst_ni && clu_valid) begin
      if (ec.size() == 0) begin
        chk(0, "R5", "unexpected beat", 1, 0);
      end else begin
        string tag = mid ? "R5" : "R3";
        chk(int'(clu_col) == ec[0], tag, "col", int'(clu_col), ec[0]);
        chk(int'(clu_row) == er[0], tag, "row", int'(clu_row), er[0]);
        chk(int'(clu_chg) == eq[0], "R7", "charge", int'(clu_chg), eq[0]);
        chk(int'(clu_last) == el[0], "R7", "last flag", int'(clu_last), el[0]);
        void'(ec.pop_front()); void'(er.pop_front());
        void'(eq.pop_front()); void'(el.pop_front());
      end
      mid = !clu_last;
      if (clu_last) n_last++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send_hit(int c, int r, int q);
    @(negedge clk);
    hit_col = COL_W'(c); hit_row = ROW_W'(r); hit_chg = CHG_W'(q);
    hit_valid = 1'b1;
    chk(in_ready == (hc.size() < DEPTH), "R9", "ready vs fill", int'(in_ready), hc.size() < DEPTH);
    if (in_ready) begin
      hc.push_back(c); hr.push_back(r); hq.push_back(q);
    end
  endtask

  task automatic run_module(output int clus, output int lat, output int exp_clus);
    int base, k;
    @(negedge clk);
    hit_valid = 1'b0;
    eom = 1'b1;
    exp_clus = build_expected();
    base = n_last;
    @(negedge clk);
    eom = 1'b0;
    k = 0; lat = -1;
    while (!in_ready) begin
      if (clu_valid && lat < 0) lat = k;
      @(negedge clk);
      k++;
    end
    chk(ec.size() == 0, "R2", "beats outstanding at ready", ec.size(), 0);
    clus = n_last - base;
    hc.delete(); hr.delete(); hq.delete();
  endtask

  initial begin
    int clus, lat, ex;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    chk(clu_valid == 1'b0, "R1", "valid after reset", int'(clu_valid), 0);

    // R2: empty module
    run_module(clus, lat, ex);
    chk(clus == 0, "R2", "clusters in empty module", clus, 0);

    // R8: lone hit latency
    send_hit(50, 100, 7);
    run_module(clus, lat, ex);
    chk(lat == 3, "R8", "lone hit latency", lat, 3);
    chk(clus == 1, "R8", "lone hit clusters", clus, 1);

    // R4: vertical chain of 23 rows splits at window depth
    for (int r = 10; r <= 32; r++) send_hit(10, r, r);
    run_module(clus, lat, ex);
    chk(clus == 2, "R4", "row window split", clus, 2);

    // R4: column edges, right side and seed near column 0
    for (int c = 20; c <= 25; c++) send_hit(c, 5, c);
    for (int c = 0; c <= 5; c++) send_hit(c, 8, 100 + c);
    run_module(clus, lat, ex);
    chk(clus == 4, "R4", "column window split", clus, 4);

    // R5: diagonal links, vertical gap does not
    send_hit(0, 0, 1); send_hit(5, 0, 2); send_hit(1, 1, 3);
    send_hit(2, 2, 4); send_hit(5, 2, 5);
    run_module(clus, lat, ex);
    chk(clus == 3, "R5", "diagonal connectivity", clus, 3);

    // R6: in-window leftovers seed later clusters
    send_hit(10, 0, 9); send_hit(12, 0, 8); send_hit(10, 3, 6);
    run_module(clus, lat, ex);
    chk(clus == 3, "R6", "leftover clusters", clus, 3);

    // R9: overflow, 40 isolated hits offered
    for (int i = 0; i < 40; i++) send_hit((i % 10) * 3, (i / 10) * 3, i);
    run_module(clus, lat, ex);
    chk(clus == DEPTH, "R9", "clusters after overflow", clus, DEPTH);

    // random hit maps around a random base
    for (int m = 0; m < 30; m++) begin
      int r0 = $urandom_range(0, 200);
      int c0 = $urandom_range(0, 200);
      int p  = $urandom_range(8, 30);
      for (int r = 0; r < 25; r++)
        for (int c = 0; c < 12; c++)
          if (hc.size() < DEPTH && $urandom_range(0, 99) < p)
            send_hit(c0 + c, r0 + r, $urandom_range(0, 255));
      run_module(clus, lat, ex);
      chk(clus == ex, "R6", "random module cluster count", clus, ex);
    end

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule